// File: doc/BRIEF.md
# Chained Channel Delay Generator

This block is a multi-channel pulse delay unit that runs on a clock taken from the time base. A start marker, T0, begins a timing cycle. Each channel then drives one pulse of a programmed width at a programmed absolute delay. The delay and the width are counted in whole clock ticks from T0, so one tick is the delay resolution.

Each channel's delay is written as a signed offset plus a reference. The reference is either T0 or another channel's programmed edge time. After any write, the block resolves the references in dependency order into absolute tick times. Changing one reference channel therefore moves every channel chained to it, and the spacing between them is kept.

A resolved time below T0 is clamped to T0 and raises a sticky warning. A reference loop, a self-reference or an invalid reference code marks the channel with a configuration error and silences it. A new T0 that arrives during a cycle restarts the tick count, and pulses still pending from the old cycle are dropped.

Top module: `chained_delay_gen`

## Requirements
- R1: When `t0` is sampled high at a clock edge, the tick count becomes 0 in the following cycle (tick 0). A channel with absolute delay d and width w drives `ch_out` high exactly in ticks d through d+w-1. A delay of 0 is high in tick 0.
- R2: A write is taken when `wr_en` is high at a clock edge. `wr_sel` selects the field: 0 is the reference code, 1 is the signed offset (all TW+1 bits of `wr_data`, two's complement), 2 is the width (low TW bits), and 3 is ignored. A write with code 3 changes no setting and does not raise `busy`.
- R3: Reference code 0 means T0, and the absolute time is the offset. Code k, for k from 1 to NCH, means channel k-1, and the absolute time is that channel's unclamped resolved time plus the offset.
- R4: Changing a reference channel's offset moves every channel chained to it by the same amount, so their relative spacing is kept.
- R5: A negative offset places a channel before its reference channel.
- R6: A resolved time below zero fires at tick 0 and sets that channel's bit in `clamp_warn`. The bit stays set until reset.
- R7: A channel whose reference chain loops, refers to itself, uses a code above NCH, or depends on such a channel has its `cfg_err` bit set and drives no pulse. The bit clears when a later write makes the chain reach T0.
- R8: A write that is taken raises `busy` for exactly NCH cycles, starting in the cycle after the write edge. New settings apply when `busy` falls. A write taken while `busy` is high restarts the NCH-cycle count.
- R9: A width of 0 produces no pulse.
- R10: A `t0` that arrives while pulses are pending restarts the count at tick 0. Edges still pending from the old cycle do not appear.
- R11: After reset, `ch_out`, `cfg_err`, `clamp_warn` and `busy` are 0, and no channel pulses until its settings have been written and resolved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock; one tick of delay |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_ch | input | $clog2(NCH) | Channel addressed by the write |
| wr_sel | input | 2 | Field select: 0 reference, 1 offset, 2 width, 3 none |
| wr_data | input | TW+1 | Write data |
| t0 | input | 1 | Start-of-cycle marker |
| ch_out | output | NCH | Channel pulse outputs |
| cfg_err | output | NCH | Per-channel unresolved reference flag |
| clamp_warn | output | NCH | Per-channel sticky negative-time warning |
| busy | output | 1 | Reference resolution in progress |

## Verification
The bench builds the block with NCH=4 and TW=8. Four channels allow a chain three levels deep, a two-channel loop with dependants hanging off it, a self-reference, and reference codes 5 to 7 that are invalid. The 8-bit tick range keeps every pattern short, so each cycle's expected output vector can be queued tick by tick. A 9-bit signed offset makes negative chains that fall below T0 simple to set up.

// File: rtl/chained_delay_gen.sv
module chained_delay_gen #(
  parameter int NCH = 4,
  parameter int TW  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NCH)-1:0]  wr_ch,
  input  logic [1:0]              wr_sel,
  input  logic [TW:0]             wr_data,
  input  logic                    t0,
  output logic [NCH-1:0]          ch_out,
  output logic [NCH-1:0]          cfg_err,
  output logic [NCH-1:0]          clamp_warn,
  output logic                    busy
);
  localparam int CW  = $clog2(NCH);
  localparam int RFW = $clog2(NCH + 1);
  localparam int RW  = TW + CW + 2;
  localparam int IW  = $clog2(NCH + 1);
  localparam logic [TW-1:0] MAXT = '1;

  logic [RFW-1:0]        ref_q  [NCH];
  logic signed [TW:0]    off_q  [NCH];
  logic [TW-1:0]         wid_q  [NCH];
  logic signed [RW-1:0]  raw_q  [NCH];
  logic signed [RW-1:0]  raw_n  [NCH];
  logic [CW-1:0]         ridx   [NCH];
  logic [TW-1:0]         fire_n [NCH];
  logic [TW-1:0]         fire_q [NCH];
  logic [TW-1:0]         wact_q [NCH];
  logic [NCH-1:0]        ok_q, ok_n, en_q, err_q, warn_q;
  logic [IW-1:0]         iter_q;
  logic [TW-1:0]         cnt_q;
  logic                  run_q;

  assign busy       = iter_q != '0;
  assign cfg_err    = err_q;
  assign clamp_warn = warn_q;

  // One relaxation step: each channel takes its reference's previous sum.
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ridx[i]  = CW'(ref_q[i] - 1'b1);
      raw_n[i] = $signed({{(RW-TW-1){off_q[i][TW]}}, off_q[i]});
      ok_n[i]  = 1'b0;
      if (ref_q[i] == '0) begin
        ok_n[i] = 1'b1;
      end else if (int'(ref_q[i]) <= NCH) begin
        raw_n[i] = raw_n[i] + raw_q[ridx[i]];
        ok_n[i]  = ok_q[ridx[i]];
      end
      if (raw_n[i] < 0)
        fire_n[i] = '0;
      else if (raw_n[i] > $signed(RW'(MAXT)))
        fire_n[i] = MAXT;
      else
        fire_n[i] = raw_n[i][TW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iter_q <= '0;
      ok_q   <= '0;
      en_q   <= '0;
      err_q  <= '0;
      warn_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        ref_q[i]  <= '0;
        off_q[i]  <= '0;
        wid_q[i]  <= '0;
        raw_q[i]  <= '0;
        fire_q[i] <= '0;
        wact_q[i] <= '0;
      end
    end else if (wr_en && wr_sel != 2'd3) begin
      case (wr_sel)
        2'd0:    ref_q[wr_ch] <= wr_data[RFW-1:0];
        2'd1:    off_q[wr_ch] <= wr_data;
        default: wid_q[wr_ch] <= wr_data[TW-1:0];
      endcase
      iter_q <= IW'(NCH);
      ok_q   <= '0;
    end else if (iter_q != '0) begin
      raw_q  <= raw_n;
      ok_q   <= ok_n;
      iter_q <= iter_q - 1'b1;
      if (iter_q == IW'(1)) begin
        for (int i = 0; i < NCH; i++) begin
          en_q[i]   <= ok_n[i];
          err_q[i]  <= !ok_n[i];
          fire_q[i] <= fire_n[i];
          wact_q[i] <= wid_q[i];
          if (ok_n[i] && raw_n[i] < 0) warn_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (t0) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == MAXT) run_q <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++)
      ch_out[i] = run_q && en_q[i] && cnt_q >= fire_q[i] &&
                  ({1'b0, cnt_q} < {1'b0, fire_q[i]} + {1'b0, wact_q[i]});
  end
endmodule

// File: rtl/chained_delay_gen_chk.sv
module chained_delay_gen_chk #(
  parameter int NCH = 4,
  parameter int TW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [1:0]     wr_sel,
  input logic           t0,
  input logic [NCH-1:0] ch_out,
  input logic [NCH-1:0] cfg_err,
  input logic [NCH-1:0] clamp_warn,
  input logic           busy,
  input logic [TW-1:0]  cnt_q,
  input logic           run_q
);
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (ch_out & cfg_err) == '0); // R7
  AST_T0_RESTART: assert property (@(posedge clk) disable iff (!rst_n) t0 |=> (cnt_q == '0 && run_q)); // R10
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n) (run_q && !t0 && cnt_q != '1) |=> cnt_q == $past(cnt_q) + 1'b1); // R1
  AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (clamp_warn & $past(clamp_warn)) == $past(clamp_warn)); // R6
  AST_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_sel != 2'd3) |=> busy); // R8
  AST_OUT_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) ch_out != '0 |-> run_q); // R11
endmodule

bind chained_delay_gen chained_delay_gen_chk #(.NCH(NCH), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .t0(t0),
  .ch_out(ch_out), .cfg_err(cfg_err), .clamp_warn(clamp_warn), .busy(busy),
  .cnt_q(cnt_q), .run_q(run_q)
);

// File: tb/sim_chained_delay_gen.sv
module sim_chained_delay_gen;
  localparam int CLK_NS = 10;
  localparam int NCH = 4;
  localparam int TW  = 8;
  localparam int MAXT = (1 << TW) - 1;

  logic clk = 0, rst_n = 0, wr_en = 0, t0 = 0;
  logic [1:0] wr_ch = 0;
  logic [1:0] wr_sel = 0;
  logic [TW:0] wr_data = 0;
  logic [NCH-1:0] ch_out, cfg_err, clamp_warn;
  logic busy;

  chained_delay_gen #(.NCH(NCH), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
    .wr_data(wr_data), .t0(t0), .ch_out(ch_out), .cfg_err(cfg_err),
    .clamp_warn(clamp_warn), .busy(busy));

  always #(CLK_NS/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  logic [NCH-1:0] exp_q[$];
  string tag_q[$];

  int b_ref[NCH], b_off[NCH], b_wid[NCH], b_abs[NCH];
  logic [NCH-1:0] b_en = 0, b_warn = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [NCH-1:0] v;
      string t;
      v = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if (ch_out !== v) begin
        mismatched++;
        $display("FAIL %s ch_out actual=%b expected=%b", t, ch_out, v);
      end
    end
  end

  function automatic void model_resolve();
    for (int i = 0; i < NCH; i++) begin
      int cur = i;
      int sum = 0;
      bit ok = 0;
      for (int s = 0; s < NCH; s++) begin
        sum += b_off[cur];
        if (b_ref[cur] == 0) begin ok = 1; break; end
        if (b_ref[cur] > NCH) break;
        cur = b_ref[cur] - 1;
      end
      b_en[i]  = ok;
      b_abs[i] = sum < 0 ? 0 : (sum > MAXT ? MAXT : sum);
      if (ok && sum < 0) b_warn[i] = 1'b1;
    end
  endfunction

  function automatic logic [NCH-1:0] exp_vec(int k);
    logic [NCH-1:0] v = '0;
    for (int i = 0; i < NCH; i++)
      v[i] = b_en[i] && k >= b_abs[i] && k < b_abs[i] + b_wid[i];
    return v;
  endfunction

  task automatic wr(int ch, int sel, int val);
    @(negedge clk);
    wr_en = 1; wr_ch = 2'(ch); wr_sel = 2'(sel); wr_data = (TW+1)'(val);
    @(negedge clk);
    wr_en = 0;
    if (sel == 0) b_ref[ch] = val;
    else if (sel == 1) b_off[ch] = val;
    else if (sel == 2) b_wid[ch] = val;
  endtask

  task automatic wr_s(int ch, int sel, int val);
    wr(ch, sel, val);
    while (busy) @(negedge clk);
    model_resolve();
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic fire(int len, string tag);
    @(negedge clk); t0 = 1;
    @(posedge clk); #1;
    for (int k = 0; k < len; k++) begin exp_q.push_back(exp_vec(k)); tag_q.push_back(tag); end
    @(negedge clk); t0 = 0;
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic fire_restart(int n, int len, string tag);
    @(negedge clk); t0 = 1;
    @(posedge clk); #1;
    for (int k = 0; k < n; k++) begin exp_q.push_back(exp_vec(k)); tag_q.push_back(tag); end
    @(negedge clk); t0 = 0;
    repeat (n - 1) @(negedge clk);
    t0 = 1;
    @(posedge clk); #1;
    for (int k = 0; k < len; k++) begin exp_q.push_back(exp_vec(k)); tag_q.push_back(tag); end
    @(negedge clk); t0 = 0;
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 100000);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    for (int i = 0; i < NCH; i++) begin b_ref[i] = 0; b_off[i] = 0; b_wid[i] = 0; b_abs[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state and idle channels
    check("R11 ch_out", 32'(ch_out), 0);
    check("R11 cfg_err", 32'(cfg_err), 0);
    check("R11 clamp_warn", 32'(clamp_warn), 0);
    check("R11 busy", 32'(busy), 0);
    fire(6, "R11");

    // R8 busy lasts NCH cycles after one write
    wr(1, 0, 1);
    busy_len(n);
    check("R8 busy length", 32'(n), NCH);
    model_resolve();
    wr_s(2, 0, 2);
    wr_s(0, 1, 10);
    wr_s(1, 1, 5);
    wr_s(2, 1, -12);
    wr_s(3, 1, 20);
    wr_s(0, 2, 3);
    wr_s(1, 2, 2);
    wr_s(2, 2, 4);
    wr_s(3, 2, 1);
    check("R3 cfg_err", 32'(cfg_err), 0);
    check("R5 clamp_warn", 32'(clamp_warn), 0);
    fire(30, "R3 R5 chain with channel before its reference");

    // R4 move the root, chained channels follow
    wr_s(0, 1, 30);
    fire(45, "R4 shifted pattern");

    // R9 zero width is silent
    wr_s(3, 2, 0);
    fire(30, "R9 zero width");
    wr_s(3, 2, 1);

    // R2 field code 3 is ignored
    wr(0, 3, 0);
    check("R2 busy stays low", 32'(busy), 0);
    fire(45, "R2 pattern unchanged");

    // R6 clamp and sticky warning
    wr_s(3, 0, 3);
    wr_s(3, 1, -40);
    check("R6 clamp_warn set", 32'(clamp_warn), 32'(b_warn));
    check("R6 clamp_warn ch3", 32'(clamp_warn), 32'h8);
    fire(40, "R6 clamped channel at tick 0");
    wr_s(3, 1, 0);
    check("R6 clamp_warn sticky", 32'(clamp_warn), 32'h8);

    // R7 loops, self-reference, invalid code
    wr_s(0, 0, 2);
    check("R7 loop cfg_err", 32'(cfg_err), 32'hF);
    fire(40, "R7 loop silent");
    wr_s(0, 0, 1);
    check("R7 self cfg_err", 32'(cfg_err), 32'hF);
    wr_s(0, 0, 7);
    check("R7 invalid code cfg_err", 32'(cfg_err), 32'hF);
    wr_s(0, 0, 0);
    check("R7 cleared cfg_err", 32'(cfg_err), 0);

    // R8 write while busy restarts the count
    wr(0, 1, 0);
    wr(0, 2, 2);
    busy_len(n);
    check("R8 restart busy length", 32'(n), NCH);
    model_resolve();

    // R1 zero delay pulses in tick 0
    fire(30, "R1 zero delay");

    // R10 retrigger drops pending edges
    wr_s(0, 1, 12);
    fire_restart(8, 40, "R10 retrigger");

    finish_run();
  end
endmodule